// File: doc/BRIEF.md
# Multi-Sector Disk Transfer Engine

This block carries out the data-moving commands of a small-computer disk adapter: sector read, sector write, track format and verify. It decodes a 21-bit starting sector number, a drive select and a sector count from the command bytes. It then moves data through a one-sector buffer. On one side is the host's byte-wide data port, paced by a data-request flag. On the other side is an abstract storage port that loads or stores one whole sector per request/acknowledge handshake.

A transfer chains as many sectors as the count asks for and advances the sector number after each one. A storage failure ends the transfer at once with the seek-error code. Format writes a fixed run of zero-filled sectors. When the engine finishes it pulses a completion flag and holds an error code. It also keeps one access indicator per drive; a read strobe returns these indicators and clears them.

Top module: `sasi_xfer_engine`

## Requirements
- R1: The starting sector number is {cmd_b1[4:0], cmd_b2, cmd_b3}, the drive is cmd_b1[5] and the count is cmd_b4. Every storage request carries the byte address sector×256 on st_addr and the drive on st_unit.
- R2: A read (opcode 0x08) or write (0x0A) with count zero finishes with err_code 0x0F and issues no storage request. A read or write whose first sector load fails (st_fail with st_ack) also finishes with 0x0F.
- R3: A read first loads the sector and holds drq low while the request is open. After a good acknowledge, drq rises and host_rdata presents buffer byte 0, then bytes 1 to 255, one per host_rd strobe.
- R4: A write loads the sector as a probe. The host then writes 256 bytes with host_wr, and the engine issues one store request whose buffer contents equal those bytes in order.
- R5: After each 256th byte the count is decremented. If it is still nonzero, the sector number is incremented and the next sector is requested. Otherwise the engine completes with err_code 0x00 and drq low.
- R6: A failed load or store partway through a transfer ends it with err_code 0x0F and drq low, and no further request is issued.
- R7: Format (0x06) stores 33 all-zero sectors at consecutive sector numbers from the start sector and completes with 0x00. A storage failure ends it with 0x0F.
- R8: Verify (0x0B) completes with err_code 0x00 without any storage request.
- R9: Each good acknowledge sets the flag of the drive on st_unit. acc_flags shows drive 0 in bit 4 and drive 1 in bit 5, and an acc_rd strobe clears both.
- R10: host_rd and host_wr have no effect while no transfer is active: host_rdata stays 0 and the buffer pointer does not move.
- R11: A storage request stays asserted, with a stable address and direction, until st_ack. There is exactly one request per sector.
- R12: done is a one-cycle pulse, and err_code holds its value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 8 | Opcode byte |
| cmd_b1 | input | 8 | Drive and high sector bits |
| cmd_b2 | input | 8 | Middle sector byte |
| cmd_b3 | input | 8 | Low sector byte |
| cmd_b4 | input | 8 | Sector count |
| host_rd | input | 1 | Host byte read strobe |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| drq | output | 1 | Host data transfer requested |
| done | output | 1 | Completion pulse |
| err_code | output | 8 | Completion error code |
| st_req | output | 1 | Storage sector request |
| st_we | output | 1 | Request is a store |
| st_addr | output | 29 | Storage byte address |
| st_unit | output | 1 | Drive for the request |
| st_ack | input | 1 | Request finished |
| st_fail | input | 1 | Request failed (with st_ack) |
| st_buf_addr | input | 8 | Storage-side buffer index |
| st_buf_we | input | 1 | Storage writes buffer (during load) |
| st_buf_wdata | input | 8 | Storage write byte |
| st_buf_rdata | output | 8 | Storage read byte |
| acc_rd | input | 1 | Read-and-clear of access flags |
| acc_flags | output | 8 | Drive access flags |

## Verification
The embedded properties watch, cycle by cycle, that open requests are held steady until acknowledged. They also check that a zero count or a failed acknowledge finishes with the seek code on the next cycle, that drq follows a good load, that done never lasts two cycles, and that a read strobe clears the flags. Byte ordering within the buffer, sector chaining with the incrementing address, the 33-sector format run and its zero contents, and the fact that idle host strobes leave the pointer untouched are only visible in the directed scenarios, where a storage model fills and captures whole sectors.

// File: rtl/sasi_xfer_pkg.sv
package sasi_xfer_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_LOAD, ST_HOST, ST_STORE, ST_FMT, ST_DONE
   } xfer_state_e;

   typedef enum logic [2:0] {
      K_NONE, K_READ, K_WRITE, K_FMT, K_VERIFY
   } cmd_kind_e;

   localparam logic [7:0] OPC_READ   = 8'h08;
   localparam logic [7:0] OPC_WRITE  = 8'h0A;
   localparam logic [7:0] OPC_FMT    = 8'h06;
   localparam logic [7:0] OPC_VERIFY = 8'h0B;
   localparam logic [7:0] ERR_NONE   = 8'h00;
   localparam logic [7:0] ERR_SEEK   = 8'h0F;
endpackage

// File: rtl/sasi_cmd_decode.sv
module sasi_cmd_decode
   import sasi_xfer_pkg::*;
#(
   parameter int HI_BITS = 5,
   parameter int UNIT_W  = 1,
   parameter int CNT_W   = 8,
   localparam int LBA_W  = HI_BITS + 16
) (
   input  logic [7:0]        op,
   input  logic [7:0]        b1,
   input  logic [7:0]        b2,
   input  logic [7:0]        b3,
   input  logic [7:0]        b4,
   output cmd_kind_e         kind,
   output logic [LBA_W-1:0]  lba,
   output logic [UNIT_W-1:0] unit,
   output logic [CNT_W-1:0]  cnt
);
   if (HI_BITS + UNIT_W > 8) begin : g_bad_split
      $error("drive field does not fit in command byte 1");
   end
   if (CNT_W > 8) begin : g_bad_cnt
      $error("count wider than its command byte");
   end

   logic unused_b1;
   assign unused_b1 = ^b1;

   assign lba  = {b1[HI_BITS-1:0], b2, b3};
   assign unit = b1[HI_BITS +: UNIT_W];
   assign cnt  = b4[CNT_W-1:0];

   always_comb begin
      unique case (op)
         OPC_READ:   kind = K_READ;
         OPC_WRITE:  kind = K_WRITE;
         OPC_FMT:    kind = K_FMT;
         OPC_VERIFY: kind = K_VERIFY;
         default:    kind = K_NONE;
      endcase
   end
endmodule

// File: rtl/sasi_sector_buf.sv
module sasi_sector_buf #(
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             st_we,
   input  logic [IDX_W-1:0] st_idx,
   input  logic [7:0]       st_wdata,
   output logic [7:0]       st_rdata,
   input  logic             host_we,
   input  logic [IDX_W-1:0] host_idx,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sector size must be a power of two");
   end

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (clr) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (st_we) begin
         mem[st_idx] <= st_wdata;
      end else if (host_we) begin
         mem[host_idx] <= host_wdata;
      end
   end

   assign st_rdata   = mem[st_idx];
   assign host_rdata = mem[host_idx];
endmodule

// File: rtl/sasi_access_flags.sv
module sasi_access_flags #(
   parameter int UNITS = 2,
   localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic [UNIT_W-1:0] set_unit,
   input  logic              clr,
   output logic [UNITS-1:0]  flags
);
   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   flags[u] <= 1'b0;
         else if (set && set_unit == UNIT_W'(u))       flags[u] <= 1'b1;
         else if (clr)                                 flags[u] <= 1'b0;
      end
   end

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set |=> flags == '0);
endmodule

// File: rtl/sasi_xfer_engine.sv
module sasi_xfer_engine
   import sasi_xfer_pkg::*;
#(
   parameter int HI_BITS     = 5,
   parameter int UNITS       = 2,
   parameter int CNT_W       = 8,
   parameter int SECT_BYTES  = 256,
   parameter int FMT_SECTORS = 33,
   parameter int FLAG_BASE   = 4,
   localparam int LBA_W  = HI_BITS + 16,
   localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1,
   localparam int PTR_W  = $clog2(SECT_BYTES),
   localparam int ADDR_W = LBA_W + PTR_W,
   localparam int FMT_W  = $clog2(FMT_SECTORS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        cmd_op,
   input  logic [7:0]        cmd_b1,
   input  logic [7:0]        cmd_b2,
   input  logic [7:0]        cmd_b3,
   input  logic [7:0]        cmd_b4,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              drq,
   output logic              done,
   output logic [7:0]        err_code,
   output logic              st_req,
   output logic              st_we,
   output logic [ADDR_W-1:0] st_addr,
   output logic [UNIT_W-1:0] st_unit,
   input  logic              st_ack,
   input  logic              st_fail,
   input  logic [PTR_W-1:0]  st_buf_addr,
   input  logic              st_buf_we,
   input  logic [7:0]        st_buf_wdata,
   output logic [7:0]        st_buf_rdata,
   input  logic              acc_rd,
   output logic [7:0]        acc_flags
);
   if (FLAG_BASE + UNITS > 8) begin : g_bad_flags
      $error("access flags do not fit in a byte");
   end
   if (FMT_SECTORS < 1) begin : g_bad_fmt
      $error("format run must cover at least one sector");
   end

   xfer_state_e       state_q;
   logic [LBA_W-1:0]  lba_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [UNIT_W-1:0] unit_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [FMT_W-1:0]  fmt_q;
   logic              wr_q;
   logic [7:0]        err_q;

   cmd_kind_e         dec_kind;
   logic [LBA_W-1:0]  dec_lba;
   logic [UNIT_W-1:0] dec_unit;
   logic [CNT_W-1:0]  dec_cnt;

   sasi_cmd_decode #(.HI_BITS(HI_BITS), .UNIT_W(UNIT_W), .CNT_W(CNT_W)) u_dec (
      .op(cmd_op), .b1(cmd_b1), .b2(cmd_b2), .b3(cmd_b3), .b4(cmd_b4),
      .kind(dec_kind), .lba(dec_lba), .unit(dec_unit), .cnt(dec_cnt)
   );

   logic good_ack, buf_clr, host_we, st_fill;
   logic [7:0] buf_host_rd;
   logic [CNT_W-1:0] cnt_dec;
   logic last_byte;

   assign st_req    = (state_q == ST_LOAD) || (state_q == ST_STORE) || (state_q == ST_FMT);
   assign st_we     = (state_q == ST_STORE) || (state_q == ST_FMT);
   assign st_addr   = {lba_q, {PTR_W{1'b0}}};
   assign st_unit   = unit_q;
   assign drq       = (state_q == ST_HOST);
   assign done      = (state_q == ST_DONE);
   assign err_code  = err_q;
   assign good_ack  = st_req && st_ack && !st_fail;
   assign cnt_dec   = cnt_q - CNT_W'(1);
   assign last_byte = (ptr_q == PTR_W'(SECT_BYTES - 1));
   assign st_fill   = st_buf_we && (state_q == ST_LOAD);
   assign host_we   = drq && wr_q && host_wr;
   assign buf_clr   = (state_q == ST_IDLE && start && dec_kind == K_FMT)
                   || (state_q == ST_LOAD && good_ack && wr_q);
   assign host_rdata = (drq && !wr_q) ? buf_host_rd : 8'h00;

   sasi_sector_buf #(.DEPTH(SECT_BYTES)) u_buf (
      .clk(clk), .clr(buf_clr),
      .st_we(st_fill), .st_idx(st_buf_addr), .st_wdata(st_buf_wdata), .st_rdata(st_buf_rdata),
      .host_we(host_we), .host_idx(ptr_q), .host_wdata(host_wdata), .host_rdata(buf_host_rd)
   );

   logic [UNITS-1:0] flag_vec;
   sasi_access_flags #(.UNITS(UNITS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(good_ack), .set_unit(unit_q),
      .clr(acc_rd), .flags(flag_vec)
   );

   always_comb begin
      acc_flags = 8'h00;
      for (int u = 0; u < UNITS; u++) acc_flags[FLAG_BASE + u] = flag_vec[u];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lba_q   <= '0;
         cnt_q   <= '0;
         unit_q  <= '0;
         ptr_q   <= '0;
         fmt_q   <= '0;
         wr_q    <= 1'b0;
         err_q   <= ERR_NONE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start && dec_kind != K_NONE) begin
               lba_q  <= dec_lba;
               cnt_q  <= dec_cnt;
               unit_q <= dec_unit;
               wr_q   <= (dec_kind == K_WRITE);
               fmt_q  <= '0;
               ptr_q  <= '0;
               if (dec_kind == K_FMT) begin
                  state_q <= ST_FMT;
               end else if (dec_kind == K_VERIFY) begin
                  state_q <= ST_DONE;
                  err_q   <= ERR_NONE;
               end else if (dec_cnt == '0) begin
                  state_q <= ST_DONE;
                  err_q   <= ERR_SEEK;
               end else begin
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: if (st_ack) begin
               if (st_fail) begin
                  state_q <= ST_DONE;
                  err_q   <= ERR_SEEK;
               end else begin
                  ptr_q   <= '0;
                  state_q <= ST_HOST;
               end
            end
            ST_HOST: if (wr_q ? host_wr : host_rd) begin
               ptr_q <= ptr_q + PTR_W'(1);
               if (last_byte) begin
                  if (wr_q) begin
                     state_q <= ST_STORE;
                  end else begin
                     cnt_q <= cnt_dec;
                     if (cnt_dec != '0) begin
                        lba_q   <= lba_q + LBA_W'(1);
                        state_q <= ST_LOAD;
                     end else begin
                        state_q <= ST_DONE;
                        err_q   <= ERR_NONE;
                     end
                  end
               end
            end
            ST_STORE: if (st_ack) begin
               if (st_fail) begin
                  state_q <= ST_DONE;
                  err_q   <= ERR_SEEK;
               end else begin
                  cnt_q <= cnt_dec;
                  if (cnt_dec != '0) begin
                     lba_q   <= lba_q + LBA_W'(1);
                     state_q <= ST_LOAD;
                  end else begin
                     state_q <= ST_DONE;
                     err_q   <= ERR_NONE;
                  end
               end
            end
            ST_FMT: if (st_ack) begin
               if (st_fail) begin
                  state_q <= ST_DONE;
                  err_q   <= ERR_SEEK;
               end else if (fmt_q == FMT_W'(FMT_SECTORS - 1)) begin
                  state_q <= ST_DONE;
                  err_q   <= ERR_NONE;
               end else begin
                  fmt_q <= fmt_q + FMT_W'(1);
                  lba_q <= lba_q + LBA_W'(1);
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_req && !st_ack |=> st_req && $stable(st_addr) && $stable(st_we));

   p_zero_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_IDLE && start && (dec_kind == K_READ || dec_kind == K_WRITE) && dec_cnt == '0
      |=> done && err_code == ERR_SEEK);

   p_fail_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_req && st_ack && st_fail |=> done && err_code == ERR_SEEK && !drq);

   p_drq_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st_req && !st_we && st_ack && !st_fail |=> drq);

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && $stable(err_code));
endmodule

// File: tb/sasi_xfer_engine_bench.sv
module sasi_xfer_engine_bench;
   localparam int CLK_NS = 10;

   logic clk = 0, rst_n = 0;
   always #(CLK_NS/2) clk = ~clk;

   logic start = 0, host_rd = 0, host_wr = 0, st_ack = 0, st_fail = 0;
   logic st_buf_we = 0, acc_rd = 0;
   logic [7:0] cmd_op = 0, cmd_b1 = 0, cmd_b2 = 0, cmd_b3 = 0, cmd_b4 = 0;
   logic [7:0] host_wdata = 0, st_buf_wdata = 0, st_buf_addr = 0;
   logic [7:0] host_rdata, err_code, st_buf_rdata, acc_flags;
   logic drq, done, st_req, st_we, st_unit;
   logic [28:0] st_addr;

   sasi_xfer_engine u_sasi_xfer_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op), .cmd_b1(cmd_b1),
      .cmd_b2(cmd_b2), .cmd_b3(cmd_b3), .cmd_b4(cmd_b4), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata), .drq(drq),
      .done(done), .err_code(err_code), .st_req(st_req), .st_we(st_we),
      .st_addr(st_addr), .st_unit(st_unit), .st_ack(st_ack), .st_fail(st_fail),
      .st_buf_addr(st_buf_addr), .st_buf_we(st_buf_we), .st_buf_wdata(st_buf_wdata),
      .st_buf_rdata(st_buf_rdata), .acc_rd(acc_rd), .acc_flags(acc_flags)
   );

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [20:0] l, input int i);
      return 8'(l[7:0] * 5 + i * 3 + 17);
   endfunction

   // storage model
   int nreq = 0, fail_at = -1;
   logic [28:0] req_addr [64];
   logic        req_we   [64];
   logic        req_unit [64];
   int          st_sum   [64];
   logic [7:0]  st_or    [64];

   initial begin
      forever begin
         @(negedge clk);
         if (st_req) begin
            automatic int idx = nreq;
            automatic logic we = st_we;
            automatic logic [28:0] a = st_addr;
            nreq++;
            if (idx < 64) begin
               req_addr[idx] = a; req_we[idx] = we; req_unit[idx] = st_unit;
               st_sum[idx] = 0; st_or[idx] = 0;
            end
            for (int i = 0; i < 256; i++) begin
               st_buf_addr = 8'(i);
               if (!we) begin
                  st_buf_we = 1; st_buf_wdata = pat(a[28:8], i);
               end else begin
                  #1;
                  if (idx < 64) begin
                     st_sum[idx] += st_buf_rdata;
                     st_or[idx] |= st_buf_rdata;
                  end
               end
               @(negedge clk);
            end
            st_buf_we = 0;
            st_ack = 1; st_fail = (idx == fail_at);
            @(negedge clk);
            st_ack = 0; st_fail = 0;
         end
      end
   end

   task automatic model_clear(input int f);
      nreq = 0; fail_at = f;
   endtask

   task automatic issue(input logic [7:0] op, b1, b2, b3, b4);
      cmd_op = op; cmd_b1 = b1; cmd_b2 = b2; cmd_b3 = b3; cmd_b4 = b4; start = 1;
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_done(output logic [7:0] e);
      while (!done) @(negedge clk);
      e = err_code;
      @(negedge clk);
   endtask

   task automatic host_read(output logic [7:0] b);
      while (!drq) @(negedge clk);
      host_rd = 1; #1 b = host_rdata;
      @(negedge clk);
      host_rd = 0;
   endtask

   task automatic host_write(input logic [7:0] b);
      while (!drq) @(negedge clk);
      host_wr = 1; host_wdata = b;
      @(negedge clk);
      host_wr = 0;
   endtask

   task automatic flags_clear();
      acc_rd = 1; @(negedge clk); acc_rd = 0;
   endtask

   task automatic t_reset();
      chk("R12 reset done", done, 0);
      chk("R3 reset drq", drq, 0);
      chk("R11 reset req", st_req, 0);
      chk("R9 reset flags", acc_flags, 0);
   endtask

   task automatic t_idle_ignore();
      logic [7:0] b; int bad = 0;
      model_clear(-1);
      for (int i = 0; i < 3; i++) begin
         host_rd = 1; host_wr = 1; host_wdata = 8'hEE; #1;
         if (host_rdata !== 8'h00) bad++;
         @(negedge clk);
      end
      host_rd = 0; host_wr = 0;
      chk("R10 idle rdata", bad, 0);
      chk("R10 idle no req", nreq, 0);
      chk("R10 idle no drq", drq, 0);
      issue(8'h08, 8'h00, 8'h00, 8'h30, 8'h01);
      host_read(b);
      chk("R10 pointer unmoved byte0", b, pat(21'h30, 0));
      for (int i = 1; i < 256; i++) host_read(b);
      chk("R3 last byte", b, pat(21'h30, 255));
      wait_done(b);
      chk("R5 single done", b, 8'h00);
   endtask

   task automatic t_read_multi();
      logic [7:0] b, e; int bad = 0;
      model_clear(-1);
      flags_clear();
      issue(8'h08, 8'h21, 8'h23, 8'h45, 8'h02);
      chk("R3 drq low while loading", drq, 0);
      chk("R3 request open", st_req, 1);
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 256; i++) begin
            host_read(b);
            if (b !== pat(21'h12345 + 21'(s), i)) bad++;
         end
      chk("R3 read data", bad, 0);
      wait_done(e);
      chk("R5 read err", e, 8'h00);
      chk("R5 drq cleared", drq, 0);
      chk("R11 one req per sector", nreq, 2);
      chk("R1 address", req_addr[0], {21'h12345, 8'h00});
      chk("R1 unit", req_unit[0], 1);
      chk("R5 next address", req_addr[1], {21'h12346, 8'h00});
      chk("R9 drive1 flag", acc_flags, 8'h20);
      flags_clear();
      chk("R9 flags cleared", acc_flags, 8'h00);
      chk("R12 err held", err_code, 8'h00);
   endtask

   task automatic t_write_multi();
      logic [7:0] e; int exp_sum [2];
      model_clear(-1);
      exp_sum[0] = 0; exp_sum[1] = 0;
      issue(8'h0A, 8'h00, 8'h01, 8'h00, 8'h02);
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 256; i++) begin
            exp_sum[s] += 8'((i ^ 8'h5A) + s);
            host_write(8'((i ^ 8'h5A) + s));
         end
      wait_done(e);
      chk("R4 write err", e, 8'h00);
      chk("R4 four requests", nreq, 4);
      chk("R4 probe load", req_we[0], 0);
      chk("R4 store dir", req_we[1], 1);
      chk("R4 store addr", req_addr[1], {21'h100, 8'h00});
      chk("R4 sector0 data", st_sum[1], exp_sum[0]);
      chk("R5 sector1 addr", req_addr[3], {21'h101, 8'h00});
      chk("R5 sector1 data", st_sum[3], exp_sum[1]);
      chk("R9 drive0 flag", acc_flags, 8'h10);
      flags_clear();
   endtask

   task automatic t_zero_count();
      logic [7:0] e;
      model_clear(-1);
      issue(8'h08, 8'h00, 8'h00, 8'h10, 8'h00);
      wait_done(e);
      chk("R2 read count0 err", e, 8'h0F);
      issue(8'h0A, 8'h00, 8'h00, 8'h10, 8'h00);
      wait_done(e);
      chk("R2 write count0 err", e, 8'h0F);
      chk("R2 no request", nreq, 0);
   endtask

   task automatic t_fail_cases();
      logic [7:0] b, e;
      model_clear(0);
      issue(8'h08, 8'h00, 8'h00, 8'h40, 8'h01);
      wait_done(e);
      chk("R2 first load fail", e, 8'h0F);
      chk("R2 one request", nreq, 1);
      chk("R2 drq never", drq, 0);
      model_clear(1);
      issue(8'h08, 8'h00, 8'h00, 8'h50, 8'h03);
      for (int i = 0; i < 256; i++) host_read(b);
      wait_done(e);
      chk("R6 mid fail err", e, 8'h0F);
      chk("R6 drq low", drq, 0);
      chk("R6 stopped", nreq, 2);
      chk("R12 done pulse", done, 0);
   endtask

   task automatic t_verify();
      logic [7:0] e;
      model_clear(-1);
      issue(8'h0B, 8'h00, 8'h00, 8'h77, 8'h05);
      wait_done(e);
      chk("R8 verify err", e, 8'h00);
      chk("R8 no request", nreq, 0);
   endtask

   task automatic t_format();
      logic [7:0] e; int bad = 0;
      model_clear(-1);
      flags_clear();
      issue(8'h06, 8'h00, 8'h02, 8'h00, 8'h01);
      wait_done(e);
      chk("R7 format err", e, 8'h00);
      chk("R7 33 sectors", nreq, 33);
      for (int k = 0; k < 33; k++)
         if (req_addr[k] !== {21'(21'h200 + k), 8'h00} || req_we[k] !== 1 || st_or[k] !== 0) bad++;
      chk("R7 consecutive zero stores", bad, 0);
      chk("R9 format flag", acc_flags, 8'h10);
      model_clear(4);
      issue(8'h06, 8'h00, 8'h03, 8'h00, 8'h01);
      wait_done(e);
      chk("R7 format fail err", e, 8'h0F);
      chk("R7 format stops", nreq, 5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_idle_ignore();
      t_read_multi();
      t_write_multi();
      t_zero_count();
      t_fail_cases();
      t_verify();
      t_format();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule